// File: doc/BRIEF.md
# NAND Strobe Timing Generator

This block paces the byte strobes of an 8-bit NAND bus. It takes one byte-transfer request at a time, either a read or a write. For each request it drives the matching active-low strobe through a programmed low phase and then a programmed high phase. A one-cycle done pulse follows. Two waits can come before the low phase. The first is a chip-enable-to-access wait, used on the first transfer after chip enable was dropped. The second is a bus turnaround wait, used when a read follows a write.

A separate counter qualifies the flash ready/busy line. It reports ready only after the line has been high for a programmed number of cycles.

All durations come from one packed timing register. Every field counts bus-clock cycles, and a field value of N gives N+1 cycles. The register is protected by a lock. A write to it takes effect only when the register write just before it was the unlock key, written to the lock register.

Top module: `nand_strobe_timer`

## Requirements
- R1: During and straight after synchronous active-low reset, `we_n` and `re_n` are 1 and `xfer_done`, `xfer_busy` and `rb_ready` are 0. The timing register resets to 0x03FFFFFF, which sets every field to its maximum value.
- R2: A write request sampled while idle drives `we_n` low for WL+1 cycles, where WL is timing bits 3:0. It then holds both strobes high for WH+1 cycles, where WH is bits 7:4. `re_n` stays high throughout. `xfer_done` is then 1 for exactly one cycle, and `xfer_busy` is 1 from the accepting edge to the end of that done cycle.
- R3: A read request behaves like a write but drives `re_n` low, for RL+1 cycles (bits 11:8). The high phase lasts RH+1 cycles (bits 15:12), and `we_n` stays high throughout.
- R4: A read whose previous completed transfer was a write first holds both strobes high for TA+1 cycles, where TA is bits 18:16. A read after a read, and any write, gets no turnaround wait. After reset, the previous transfer counts as a read.
- R5: The first transfer accepted after `ce_en` was seen low first holds both strobes high for CA+1 cycles, where CA is bits 25:24. This wait comes before any turnaround wait. Reset counts as chip enable having been low.
- R6: `rb_ready` drops after the first clock edge that samples `nand_rb` low. It rises after the (BD+1)-th consecutive edge that samples `nand_rb` high, where BD is bits 23:19.
- R7: A write to the timing register (`reg_sel`=1) is applied only when the register write just before it was 0x0000A25E to the lock register (`reg_sel`=0). Any other earlier write, or none, means the value is discarded. Every register write uses up the unlock.
- R8: `xfer_req` is ignored while `xfer_busy` is 1, including the done cycle. A request held through a transfer starts no further transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register target: 0 lock register, 1 timing register |
| reg_wdata | input | 32 | Register write data |
| ce_en | input | 1 | Chip enable level; low arms the access wait |
| xfer_req | input | 1 | Byte transfer request, sampled while idle |
| xfer_read | input | 1 | Direction of the request: 1 read, 0 write |
| nand_rb | input | 1 | Flash ready/busy line, 1 ready |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| xfer_done | output | 1 | One-cycle pulse ending a transfer |
| xfer_busy | output | 1 | Transfer in progress |
| rb_ready | output | 1 | Ready line high for the programmed delay |

## Verification
A sweep runs over 256 timing words. In each one the write-low and write-high fields take every pairing, and the other fields are derived so that each of them takes every value of its own range. Each word drives a fresh write (access wait and no turnaround), then a read (turnaround), then a second read (no turnaround). The outputs are compared cycle by cycle against segment lengths computed from the fields. This separates off-by-one phase lengths, wrong field positions, missing or misplaced waits, and swapped strobes. The ready-delay count is measured for every busy-field value. Lock sequences check that a locked write is discarded, that a wrong key or an upper-bit-corrupted key is rejected, and that a second write after a single unlock is discarded. In each case the proof is the strobe widths seen afterwards.

// File: rtl/nst_pkg.sv
// Package: shared field layout, state encoding and register constants for
// the NAND strobe timing generator. Field positions are fixed by software.
package nst_pkg;
    localparam int PH_W   = 4;   // width of the four strobe phase fields
    localparam int TRN_W  = 3;   // width of the turnaround field
    localparam int BSY_W  = 5;   // width of the post-busy delay field
    localparam int CEA_W  = 2;   // width of the chip-enable access field
    localparam int REG_W  = 32;  // register bus width
    localparam logic [REG_W-1:0] LOCK_KEY = 32'h0000_A25E;

    // Packed in bit order, MSB first: bits 25:24 down to bits 3:0
    typedef struct packed {
        logic [CEA_W-1:0] cea;
        logic [BSY_W-1:0] bsy;
        logic [TRN_W-1:0] trn;
        logic [PH_W-1:0]  rh;
        logic [PH_W-1:0]  rl;
        logic [PH_W-1:0]  wh;
        logic [PH_W-1:0]  wl;
    } timing_t;

    localparam int TIM_W = $bits(timing_t);

    typedef enum logic [2:0] {
        S_IDLE, S_CEA, S_TURN, S_LOW, S_HIGH, S_DONE
    } phase_e;
endpackage

// File: rtl/nst_regs.sv
// Module: lock-protected timing register.
// Assumes at most one register write per cycle. The unlock flag lasts for
// exactly one register write, whatever that write targets.
module nst_regs
    import nst_pkg::*;
#(
    parameter logic [TIM_W-1:0] TIMING_RESET = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output timing_t          tim
);
    logic             unlocked;
    logic [TIM_W-1:0] timing_q;

    // Unlock tracking and guarded timing register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
            timing_q <= TIMING_RESET;
        end else if (wr_en) begin
            unlocked <= (wr_sel == 1'b0) && (wr_data == LOCK_KEY);
            if (wr_sel && unlocked)
                timing_q <= wr_data[TIM_W-1:0];
        end
    end

    assign tim = timing_t'(timing_q);

    assert_locked_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && !unlocked) |=> $stable(timing_q));
    assert_unlock_consumed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> !unlocked);
endmodule

// File: rtl/nst_busy_delay.sv
// Module: post-busy delay. Qualifies the flash ready line so that ready is
// reported only after the line has been high for delay+1 sampled edges.
// Assumes nand_rb is already synchronous to clk.
module nst_busy_delay
    import nst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nand_rb,
    input  logic [BSY_W-1:0] delay,
    output logic             rb_ready
);
    logic [BSY_W-1:0] cnt;

    // Reload while busy, count down while ready before qualifying
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            rb_ready <= 1'b0;
        end else if (!nand_rb) begin
            cnt      <= delay;
            rb_ready <= 1'b0;
        end else if (!rb_ready) begin
            if (cnt == '0) rb_ready <= 1'b1;
            else           cnt <= cnt - 1'b1;
        end
    end

    assert_rb_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_rb |=> !rb_ready);
    assert_rb_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_ready && nand_rb) |=> rb_ready);
endmodule

// File: rtl/nst_phase_seq.sv
// Module: transfer phase sequencer. Runs the optional access wait, the
// optional turnaround wait, the strobe low phase, the high phase and a done
// cycle. Each phase lasts its field value plus one cycle. Field values are
// sampled when a phase is entered.
module nst_phase_seq
    import nst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_read,
    input  logic             ce_en,
    input  logic [PH_W-1:0]  t_wl,
    input  logic [PH_W-1:0]  t_wh,
    input  logic [PH_W-1:0]  t_rl,
    input  logic [PH_W-1:0]  t_rh,
    input  logic [TRN_W-1:0] t_trn,
    input  logic [CEA_W-1:0] t_cea,
    output logic             we_n,
    output logic             re_n,
    output logic             done,
    output logic             busy
);
    phase_e          state, succ;
    logic [PH_W-1:0] cnt, nxt_cnt;
    logic            dir_read, last_write, ce_fresh, load_dir;

    // Successor phase and the count to load on entering it
    always_comb begin
        load_dir = (state == S_IDLE) ? req_read : dir_read;
        unique case (state)
            S_IDLE:  succ = ce_fresh ? S_CEA :
                            ((req_read && last_write) ? S_TURN : S_LOW);
            S_CEA:   succ = (dir_read && last_write) ? S_TURN : S_LOW;
            S_TURN:  succ = S_LOW;
            S_LOW:   succ = S_HIGH;
            S_HIGH:  succ = S_DONE;
            default: succ = S_IDLE;
        endcase
        unique case (succ)
            S_CEA:   nxt_cnt = {{(PH_W-CEA_W){1'b0}}, t_cea};
            S_TURN:  nxt_cnt = {{(PH_W-TRN_W){1'b0}}, t_trn};
            S_LOW:   nxt_cnt = load_dir ? t_rl : t_wl;
            S_HIGH:  nxt_cnt = load_dir ? t_rh : t_wh;
            default: nxt_cnt = '0;
        endcase
    end

    // Phase state, phase counter and direction history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            cnt        <= '0;
            dir_read   <= 1'b1;
            last_write <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (req) begin
                    state    <= succ;
                    cnt      <= nxt_cnt;
                    dir_read <= req_read;
                end
                S_DONE: begin
                    state      <= S_IDLE;
                    last_write <= !dir_read;
                end
                default: if (cnt == '0) begin
                    state <= succ;
                    cnt   <= nxt_cnt;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            endcase
        end
    end

    // Access-wait arming: set while deselected, cleared when the wait starts
    always_ff @(posedge clk) begin
        if (!rst_n)                               ce_fresh <= 1'b1;
        else if (!ce_en)                          ce_fresh <= 1'b1;
        else if (state == S_IDLE && req && ce_fresh) ce_fresh <= 1'b0;
    end

    assign we_n = !(state == S_LOW && !dir_read);
    assign re_n = !(state == S_LOW && dir_read);
    assign done = (state == S_DONE);
    assign busy = (state != S_IDLE);

    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we_n || re_n);
    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_turn_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TURN) |-> (dir_read && last_write));
    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: rtl/nand_strobe_timer.sv
// Module: top of the NAND strobe timing generator. Joins the locked timing
// register, the transfer phase sequencer and the post-busy delay counter.
// Assumes all inputs are synchronous to clk.
module nand_strobe_timer
    import nst_pkg::*;
#(
    parameter logic [TIM_W-1:0] TIMING_RESET = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             ce_en,
    input  logic             xfer_req,
    input  logic             xfer_read,
    input  logic             nand_rb,
    output logic             we_n,
    output logic             re_n,
    output logic             xfer_done,
    output logic             xfer_busy,
    output logic             rb_ready
);
    timing_t tim;

    nst_regs #(.TIMING_RESET(TIMING_RESET)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_sel(reg_sel),
        .wr_data(reg_wdata), .tim(tim)
    );

    nst_phase_seq u_seq (
        .clk(clk), .rst_n(rst_n), .req(xfer_req), .req_read(xfer_read),
        .ce_en(ce_en), .t_wl(tim.wl), .t_wh(tim.wh), .t_rl(tim.rl),
        .t_rh(tim.rh), .t_trn(tim.trn), .t_cea(tim.cea),
        .we_n(we_n), .re_n(re_n), .done(xfer_done), .busy(xfer_busy)
    );

    nst_busy_delay u_bsy (
        .clk(clk), .rst_n(rst_n), .nand_rb(nand_rb), .delay(tim.bsy),
        .rb_ready(rb_ready)
    );
endmodule

// File: tb/nand_strobe_timer_test.sv
// Bench: sweeps timing words and checks strobe sequences cycle by cycle
// against segment lengths computed from the programmed fields.
module nand_strobe_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        ce_en = 1'b1, xfer_req = 1'b0, xfer_read = 1'b0, nand_rb = 1'b1;
    logic        we_n, re_n, xfer_done, xfer_busy, rb_ready;

    int checks = 0, errors = 0, cycles = 0;
    int m_wl, m_wh, m_rl, m_rh, m_trn, m_bsy, m_cea;
    bit tb_fresh = 1'b1, tb_last_write = 1'b0;

    nand_strobe_timer uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ce_en(ce_en), .xfer_req(xfer_req),
        .xfer_read(xfer_read), .nand_rb(nand_rb), .we_n(we_n), .re_n(re_n),
        .xfer_done(xfer_done), .xfer_busy(xfer_busy), .rb_ready(rb_ready)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 190000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic set_model(input logic [31:0] v);
        m_wl = v[3:0]; m_wh = v[7:4]; m_rl = v[11:8]; m_rh = v[15:12];
        m_trn = v[18:16]; m_bsy = v[23:19]; m_cea = v[25:24];
    endtask

    task automatic write_reg(input logic sel, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(posedge clk);
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic set_timing(input logic [31:0] v);
        write_reg(1'b0, 32'h0000_A25E);
        write_reg(1'b1, v);
        set_model(v);
    endtask

    task automatic pulse_ce;
        @(negedge clk); ce_en = 1'b0;
        @(posedge clk);
        @(negedge clk); ce_en = 1'b1;
        tb_fresh = 1'b1;
    endtask

    // One transfer; compares {we_n,re_n,done,busy} at every cycle
    task automatic run_xfer(input logic rd, input bit poke, input string tag);
        int c, t, l, h, total, bad_i;
        logic [3:0] exp_v, act_v, bad_a, bad_e;
        c = tb_fresh ? m_cea + 1 : 0;
        t = (rd && tb_last_write) ? m_trn + 1 : 0;
        l = (rd ? m_rl : m_wl) + 1;
        h = (rd ? m_rh : m_wh) + 1;
        total = c + t + l + h + 1;
        bad_i = -1; bad_a = '0; bad_e = '0;
        @(negedge clk); xfer_req = 1'b1; xfer_read = rd;
        @(posedge clk);
        for (int i = 0; i <= total + 2; i++) begin
            @(negedge clk);
            if (i == 0) xfer_req = poke;
            if (i == total) xfer_req = 1'b0;
            if (i < c + t)              exp_v = 4'b1101;
            else if (i < c + t + l)     exp_v = rd ? 4'b1001 : 4'b0101;
            else if (i < c + t + l + h) exp_v = 4'b1101;
            else if (i == total - 1)    exp_v = 4'b1111;
            else                        exp_v = 4'b1100;
            act_v = {we_n, re_n, xfer_done, xfer_busy};
            if (act_v !== exp_v && bad_i < 0) begin
                bad_i = i; bad_a = act_v; bad_e = exp_v;
            end
        end
        checks++;
        if (bad_i >= 0) begin
            errors++;
            $display("FAIL %s: cycle %0d we_n,re_n,done,busy actual %b expected %b",
                     tag, bad_i, bad_a, bad_e);
        end
        tb_fresh = 1'b0;
        tb_last_write = !rd;
    endtask

    // Measures the ready qualification delay against the busy field
    task automatic run_rb(input string tag);
        int k;
        @(negedge clk); nand_rb = 1'b0;
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (rb_ready !== 1'b0) begin
            errors++;
            $display("FAIL %s: rb_ready after busy actual %b expected 0", tag, rb_ready);
        end
        nand_rb = 1'b1;
        k = 0;
        while (k < 40) begin
            @(posedge clk); @(negedge clk); k++;
            if (rb_ready === 1'b1) break;
        end
        checks++;
        if (k != m_bsy + 1) begin
            errors++;
            $display("FAIL %s: ready delay actual %0d expected %0d", tag, k, m_bsy + 1);
        end
    endtask

    initial begin
        logic [31:0] v;
        set_model(32'h03FF_FFFF);
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if ({we_n, re_n, xfer_done, xfer_busy, rb_ready} !== 5'b11000) begin
            errors++;
            $display("FAIL R1: reset outputs actual %b expected 11000",
                     {we_n, re_n, xfer_done, xfer_busy, rb_ready});
        end
        rst_n = 1'b1;
        run_xfer(1'b0, 1'b0, "R1 R5 reset timing write");
        run_xfer(1'b1, 1'b0, "R1 R4 reset timing read");

        // R7: locked write discarded
        write_reg(1'b1, 32'h0000_0000);
        run_xfer(1'b0, 1'b0, "R7 locked write");
        // R7: wrong key, then a key with upper bits set
        write_reg(1'b0, 32'h0000_1234);
        write_reg(1'b1, 32'h0000_0000);
        run_xfer(1'b0, 1'b0, "R7 wrong key");
        write_reg(1'b0, 32'h0001_A25E);
        write_reg(1'b1, 32'h0000_0000);
        run_xfer(1'b1, 1'b0, "R7 key upper bits");
        // R7: one unlock admits one write only
        set_timing(32'h0000_2314);
        write_reg(1'b1, 32'h0000_0000);
        run_xfer(1'b0, 1'b0, "R7 applied then second discarded");
        run_xfer(1'b1, 1'b0, "R7 R4 read after write");

        // Sweep of timing words
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                v = '0;
                v[3:0]   = a[3:0];
                v[7:4]   = b[3:0];
                v[11:8]  = 4'(15 - a);
                v[15:12] = a[3:0] ^ b[3:0];
                v[18:16] = 3'(a + b);
                v[23:19] = 5'(a * 2 + b);
                v[25:24] = b[1:0] ^ a[3:2];
                v[31:26] = 6'h2A;
                set_timing(v);
                pulse_ce();
                run_xfer(1'b0, 1'b0, "R5 R2 sweep write");
                run_xfer(1'b1, 1'b0, "R4 R3 sweep read after write");
                run_xfer(1'b1, 1'b1, "R8 R3 sweep read after read");
                run_rb("R6 sweep");
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule